// File: doc/BRIEF.md
# Addressable Load Switch Register

This block holds a bank of on/off switch outputs that a host drives through a single 16-bit command word. The low byte of the word picks a channel, the next four bits pick a device, and the top four bits carry option flags. When the device field equals this block's own code, the block either changes the addressed switch or presents that switch's state on a 2-bit read port, together with the position of a front-panel enable input.

Two safeguards keep a stuck or repeated command word from disturbing the loads. First, the front-panel enable input, when low, stops every change requested by software. Second, a write takes effect only once. After a write command has been seen, no further write is accepted until the command bus has gone back to the all-zero idle word. A small two-state machine tracks this. In `ST_WAIT_IDLE`, writes are locked out. The transition "idle word seen" moves it to `ST_ARMED`. In `ST_ARMED`, the transition "write accepted" fires on any write addressed to this device and returns the machine to `ST_WAIT_IDLE`. Reads never change the state, so any number of reads may follow one another without an idle word between them.

Top module: `load_switch_bank`

## Requirements
- R1: Command word fields: bits 7..0 are the channel, bits 11..8 the device code, and bits 15..12 the options. The block responds only to device code 2. Option bit 12 is the mode (0 read, 1 write) and bit 13 is the value to write. Bits 14 and 15 have no effect.
- R2: While the device field is 2 and the channel is below 32, `rd_data[0]` shows the addressed switch and `rd_data[1]` shows `panel_enable` (1 = enabled). This holds for either mode, and for any number of back-to-back reads.
- R3: Reset drives all 32 switches off and places the machine in `ST_WAIT_IDLE`. A write word that is present when reset is released therefore has no effect until an idle word has been seen.
- R4: In `ST_ARMED`, a write command to a valid channel loads bit 13 into the addressed switch at the clock edge where the command is sampled. The new state is visible on `sw_out` and `rd_data` from then on.
- R5: When `panel_enable` is 0, write commands change no switch. Such a command still counts as a write and moves the machine to `ST_WAIT_IDLE`.
- R6: After any write command addressed to device 2, every later write is ignored until an all-zero word is sampled. A write sampled in the cycle after that zero word is accepted. Reads and words for other devices leave the machine armed.
- R7: `rd_data` is 0 when the device field is not 2 or the channel is above 31. Writes with such fields change no switch.
- R8: An accepted write changes only the addressed switch. All other switches keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_word | input | 16 | Command word: channel, device and option fields |
| panel_enable | input | 1 | Front-panel switch, 1 allows software changes |
| sw_out | output | 32 | Switch drive lines, 1 = on |
| rd_data | output | 2 | Bit 0 is the addressed switch, bit 1 is the panel enable |

## Verification
The bound checker watches the switch outputs on every cycle. It confirms that any change follows a sampled write to this device with the panel enabled, that two changes never occur on consecutive edges (the idle-word lockout), and that read data is nonzero only for a valid address on this device, with bit 1 never set while the panel is disabled. The bench's scenarios are needed to show three things the checker cannot: that only the addressed switch moves, that reads and foreign-device words leave the machine armed, and that a write held across the release of reset is ignored.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

    typedef enum logic {
        ST_WAIT_IDLE = 1'b0,
        ST_ARMED     = 1'b1
    } arm_state_e;

endpackage

// File: rtl/lsw_decode.sv
module lsw_decode #(
    parameter int N_SW   = 32,
    parameter int CHAN_W = 8,
    parameter int DEV_W  = 4,
    parameter int OPT_W  = 4,
    parameter int DEV_ID = 2,
    localparam int WORD_W = CHAN_W + DEV_W + OPT_W,
    localparam int IDX_W  = $clog2(N_SW),
    localparam int MODE_B = CHAN_W + DEV_W,
    localparam int VAL_B  = MODE_B + 1
) (
    input  logic [WORD_W-1:0] cmd,
    output logic              dev_hit,
    output logic              chan_ok,
    output logic              wr_cmd,
    output logic              wr_val,
    output logic              bus_idle,
    output logic [IDX_W-1:0]  idx
);
    logic [CHAN_W-1:0] chan;
    logic [DEV_W-1:0]  dev;

    always_comb begin
        chan     = cmd[CHAN_W-1:0];
        dev      = cmd[MODE_B-1:CHAN_W];
        dev_hit  = (dev == DEV_W'(DEV_ID));
        chan_ok  = (int'(chan) < N_SW);
        wr_cmd   = dev_hit && cmd[MODE_B];
        wr_val   = cmd[VAL_B];
        bus_idle = (cmd == '0);
        idx      = chan[IDX_W-1:0];
    end
endmodule

// File: rtl/lsw_arm_fsm.sv
module lsw_arm_fsm
    import lsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic wr_cmd,
    output logic wr_fire
);
    arm_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_IDLE: if (bus_idle) state_nx = ST_ARMED;
            ST_ARMED:     if (wr_cmd)   state_nx = ST_WAIT_IDLE;
            default:      state_nx = ST_WAIT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        wr_fire = 1'b0;
        unique case (state)
            ST_WAIT_IDLE: wr_fire = 1'b0;
            ST_ARMED:     wr_fire = wr_cmd;
            default:      wr_fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsw_switch_bank.sv
module lsw_switch_bank #(
    parameter int N_SW = 32,
    localparam int IDX_W = $clog2(N_SW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    output logic [N_SW-1:0]  sw_q
);
    for (genvar i = 0; i < N_SW; i++) begin : g_sw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               sw_q[i] <= 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(i)))  sw_q[i] <= wr_val;
        end
    end
endmodule

// File: rtl/load_switch_bank.sv
module load_switch_bank #(
    parameter int N_SW   = 32,
    parameter int CHAN_W = 8,
    parameter int DEV_W  = 4,
    parameter int OPT_W  = 4,
    parameter int DEV_ID = 2,
    localparam int WORD_W = CHAN_W + DEV_W + OPT_W,
    localparam int IDX_W  = $clog2(N_SW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              panel_enable,
    output logic [N_SW-1:0]   sw_out,
    output logic [1:0]        rd_data
);
    logic             dev_hit, chan_ok, wr_cmd, wr_val, bus_idle, wr_fire;
    logic [IDX_W-1:0] idx;

    lsw_decode #(
        .N_SW(N_SW), .CHAN_W(CHAN_W), .DEV_W(DEV_W), .OPT_W(OPT_W), .DEV_ID(DEV_ID)
    ) u_dec (
        .cmd(cmd_word), .dev_hit(dev_hit), .chan_ok(chan_ok), .wr_cmd(wr_cmd),
        .wr_val(wr_val), .bus_idle(bus_idle), .idx(idx)
    );

    lsw_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .wr_cmd(wr_cmd), .wr_fire(wr_fire)
    );

    lsw_switch_bank #(.N_SW(N_SW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_fire && chan_ok && panel_enable),
        .wr_idx(idx), .wr_val(wr_val), .sw_q(sw_out)
    );

    always_comb begin
        if (dev_hit && chan_ok) rd_data = {panel_enable, sw_out[idx]};
        else                    rd_data = 2'b00;
    end
endmodule

// File: rtl/load_switch_bank_chk.sv
module load_switch_bank_chk #(
    parameter int N_SW   = 32,
    parameter int CHAN_W = 8,
    parameter int DEV_W  = 4,
    parameter int OPT_W  = 4,
    parameter int DEV_ID = 2,
    localparam int WORD_W = CHAN_W + DEV_W + OPT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] cmd_word,
    input logic              panel_enable,
    input logic [N_SW-1:0]   sw_out,
    input logic [1:0]        rd_data
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_change_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(sw_out)) |-> $past(panel_enable));

    p_change_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(sw_out)) |->
            ($past(cmd_word[CHAN_W+DEV_W-1:CHAN_W]) == DEV_W'(DEV_ID)
             && $past(cmd_word[CHAN_W+DEV_W])));

    p_no_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(sw_out)) |=> $stable(sw_out));

    p_one_switch_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ($countones(sw_out ^ $past(sw_out)) <= 1));

    p_rd_zero_off_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != 2'b00) |->
            (cmd_word[CHAN_W+DEV_W-1:CHAN_W] == DEV_W'(DEV_ID)
             && int'(cmd_word[CHAN_W-1:0]) < N_SW));

    p_rd_enable_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] |-> panel_enable);
endmodule

bind load_switch_bank load_switch_bank_chk #(
    .N_SW(N_SW), .CHAN_W(CHAN_W), .DEV_W(DEV_W), .OPT_W(OPT_W), .DEV_ID(DEV_ID)
) u_chk (.*);

// File: tb/sim_load_switch_bank.sv
module sim_load_switch_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd_word = 16'h0000;
    logic        panel_enable = 1'b1;
    logic [31:0] sw_out;
    logic [1:0]  rd_data;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    load_switch_bank u0 (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .panel_enable(panel_enable),
        .sw_out(sw_out), .rd_data(rd_data)
    );

    // row: {cmd, enable, expected rd_data, expected sw_out} after the sampling edge
    localparam int NROW = 21;
    localparam logic [50:0] VEC [NROW] = '{
        {16'h0000, 1'b1, 2'd0, 32'h0000_0000},
        {16'h3205, 1'b1, 2'd3, 32'h0000_0020},
        {16'h3206, 1'b1, 2'd2, 32'h0000_0020},
        {16'h0000, 1'b1, 2'd0, 32'h0000_0020},
        {16'h0205, 1'b1, 2'd3, 32'h0000_0020},
        {16'h0205, 1'b1, 2'd3, 32'h0000_0020},
        {16'h3206, 1'b1, 2'd3, 32'h0000_0060},
        {16'h0000, 1'b1, 2'd0, 32'h0000_0060},
        {16'h321F, 1'b1, 2'd3, 32'h8000_0060},
        {16'h0000, 1'b1, 2'd0, 32'h8000_0060},
        {16'h1205, 1'b1, 2'd2, 32'h8000_0040},
        {16'h0000, 1'b1, 2'd0, 32'h8000_0040},
        {16'h3228, 1'b1, 2'd0, 32'h8000_0040},
        {16'h0000, 1'b1, 2'd0, 32'h8000_0040},
        {16'h3307, 1'b1, 2'd0, 32'h8000_0040},
        {16'h3207, 1'b1, 2'd3, 32'h8000_00C0},
        {16'h0000, 1'b0, 2'd0, 32'h8000_00C0},
        {16'h3200, 1'b0, 2'd0, 32'h8000_00C0},
        {16'h0000, 1'b1, 2'd0, 32'h8000_00C0},
        {16'h021F, 1'b0, 2'd1, 32'h8000_00C0},
        {16'h0206, 1'b1, 2'd3, 32'h8000_00C0}
    };
    string TAG [NROW] = '{
        "R6 arm", "R4 write", "R6 locked", "R6 arm", "R2 read",
        "R2 reread", "R6 armed after reads", "R6 arm", "R4 top channel", "R6 arm",
        "R4 write off", "R6 arm", "R7 channel 40", "R6 arm", "R7 other device",
        "R8 single switch", "R5 arm disabled", "R5 disabled write", "R6 arm", "R2 enable bit",
        "R8 others kept"
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] c, input logic en);
        @(negedge clk);
        cmd_word = c;
        panel_enable = en;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset sw_out", sw_out, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NROW; i++) begin
            step(VEC[i][50:35], VEC[i][34]);
            check({TAG[i], " sw_out"}, sw_out, VEC[i][31:0]);
            check({TAG[i], " rd_data"}, {30'd0, rd_data}, {30'd0, VEC[i][33:32]});
        end

        // R1: upper option bits with mode 0 are a plain read
        step(16'hC206, 1'b1);
        check("R1 options 14/15 sw_out", sw_out, 32'h8000_00C0);
        check("R1 options 14/15 rd_data", {30'd0, rd_data}, 32'd3);

        // R3: reset with a write word held across release
        @(negedge clk);
        cmd_word = 16'h3201;
        rst_n = 1'b0;
        #1;
        check("R3 async clear", sw_out, 32'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 held write ignored", sw_out, 32'h0);
        check("R3 held write rd_data", {30'd0, rd_data}, 32'd2);
        step(16'h0000, 1'b1);
        step(16'h3201, 1'b1);
        check("R6 write after zero", sw_out, 32'h0000_0002);
        check("R4 rd after write", {30'd0, rd_data}, 32'd3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule